// File: doc/BRIEF.md
# Programmable Binary Interval Timer

This block divides a slow count input by a selectable power of two. A 24-stage binary counter advances once for each falling edge of the count input. The count input is first brought into the system clock domain, so it may be asynchronous. A four-bit stage code chooses one of sixteen counter stages to drive the timer output. A skip control moves that window of sixteen stages toward the low end of the chain.

Two controls act at the next system clock edge. Clear empties the chain and holds the output low. Preload empties the chain and holds the output high, and it stays high until the first count edge after it is released. A hold input freezes the count. A self-test mode splits the chain into three independent 8-stage sections, so every stage can be filled in 255 edges. In pulse mode the output becomes a short pulse with a programmable width in system clock cycles, and it fires each time the selected stage rises.

Top module: `prog_interval_timer`

## Requirements
- R1: Each falling edge of `countIn` increments the 24-bit stage count by one, and the new value is visible at the output within 3 system clock cycles. A rising edge changes nothing.
- R2: With `skipIn` low, stage code s (0 to 15, bit 3 most significant) routes count bit 8+s (stage 9+s) to `timerOut`, giving a square wave whose period is 2^(9+s) count edges.
- R3: With `skipIn` high, stage code s routes count bit s (stage 1+s) to `timerOut`.
- R4: While `clearIn` is high, and not all three of `clearIn`, `preloadIn` and `skipIn` are high, the count is emptied and `timerOut` is low. Clear wins over preload when `skipIn` is low.
- R5: While `preloadIn` is high and `clearIn` is low, the count is emptied and `timerOut` is high. After release the output stays high. The first falling count edge drives it low without counting, and counting starts on the second edge.
- R6: While `holdIn` is high, falling count edges are ignored and the count is frozen. The first edge after `holdIn` falls counts again.
- R7: With `clearIn`, `preloadIn` and `skipIn` all high, the count is not emptied. Each 8-bit section (bits 7:0, 15:8, 23:16) counts falling edges on its own with no carry between sections, so 255 edges fill every stage with one.
- R8: Dropping `clearIn` and `preloadIn` together leaves test mode without changing the count. The next edge carries across all 24 stages, so an all-ones count rolls over to all zeros.
- R9: With `pulseEn` high, `timerOut` is low except for a pulse each time the selected stage rises. For stage n, the first pulse comes on edge 2^(n-1) after clearing, and later pulses repeat every 2^n edges.
- R10: Each pulse lasts `pulseWidth` system clock cycles, and a width of 0 gives a one-cycle pulse.
- R11: Asynchronous `rstN` low empties the count, disarms preload and drives `timerOut` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low system reset |
| countIn | input | 1 | Count input; falling edges advance the counter |
| clearIn | input | 1 | Empties the count and forces the output low |
| preloadIn | input | 1 | Empties the count and arms the output high |
| holdIn | input | 1 | Freezes the count |
| skipIn | input | 1 | Selects stages 1 to 16 instead of 9 to 24 |
| stageSel | input | 4 | Stage code |
| pulseEn | input | 1 | Enables pulse output mode |
| pulseWidth | input | 8 | Pulse length in system clock cycles (0 means 1) |
| timerOut | output | 1 | Timer output |

## Verification
A bad count bit can stay hidden until the stage code selects it. For that reason the vector walk reads all 32 routings after each preset count. A wrong section boundary or a missing carry shows up only at the first edge that crosses it. Test-mode loading puts those crossings within a few hundred edges instead of millions.

A stale preload latch shows as one extra count or one missing count on the second edge. A wrong pulse counter changes the number of high cycles seen after a single trigger.

// File: rtl/timer_pkg.sv
`timescale 1ns/1ps
package timer_pkg;
  typedef struct packed {
    logic clearAll;    // empty every stage this cycle
    logic stepSeries;  // advance the full 24-bit chain
    logic stepSplit;   // advance each 8-bit section on its own
    logic forceLow;    // hold output low
    logic forceHigh;   // hold output high (preload or armed latch)
  } timerStrobe_t;
endpackage

// File: rtl/timer_ctrl.sv
`timescale 1ns/1ps
module timer_ctrl #(
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   countIn,
  input  logic                   clearIn,
  input  logic                   preloadIn,
  input  logic                   holdIn,
  input  logic                   skipIn,
  output timer_pkg::timerStrobe_t strobe
);
  // syncPipe[SYNC_STAGES] is one cycle older than syncPipe[SYNC_STAGES-1]
  logic [SYNC_STAGES:0] syncPipe;
  logic fallEdge, splitMode, clrMode, loadHigh, edgeOk, armed;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncPipe <= '0;
    else       syncPipe <= {syncPipe[SYNC_STAGES-1:0], countIn};
  end

  assign fallEdge  = syncPipe[SYNC_STAGES] & ~syncPipe[SYNC_STAGES-1];
  assign splitMode = clearIn & preloadIn & skipIn;
  assign clrMode   = (clearIn | preloadIn) & ~splitMode;
  assign loadHigh  = preloadIn & ~clearIn;
  assign edgeOk    = fallEdge & ~holdIn;

  // output conditioning latch: armed by preload, spent by first count edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          armed <= 1'b0;
    else if (clrMode)   armed <= loadHigh;
    else if (splitMode) armed <= 1'b0;
    else if (edgeOk)    armed <= 1'b0;
  end

  always_comb begin
    strobe.clearAll   = clrMode;
    strobe.stepSeries = edgeOk & ~armed & ~splitMode & ~clrMode;
    strobe.stepSplit  = edgeOk & splitMode;
    strobe.forceLow   = clearIn & ~splitMode;
    strobe.forceHigh  = loadHigh | armed;
  end
endmodule

// File: rtl/timer_datapath.sv
`timescale 1ns/1ps
module timer_datapath #(
  parameter int STAGES  = 24,
  parameter int SECTION = 8,
  parameter int SKIP    = 8,
  parameter int SEL_W   = 4,
  parameter int PW_W    = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  timer_pkg::timerStrobe_t strobe,
  input  logic                    skipIn,
  input  logic [SEL_W-1:0]        stageSel,
  input  logic                    pulseEn,
  input  logic [PW_W-1:0]         pulseWidth,
  output logic [STAGES-1:0]       stageCount,
  output logic                    timerOut
);
  localparam int NUM_SEC = STAGES / SECTION;
  localparam int IDX_W   = $clog2(STAGES);

  logic [STAGES-1:0] splitNext;
  logic [IDX_W-1:0]  selIdx;
  logic              selBit, prevSel, trigger;
  logic [PW_W-1:0]   pulseCnt, loadVal;

  // per-section increment used in self-test mode (no carry between sections)
  for (genvar g = 0; g < NUM_SEC; g++) begin : g_sec
    assign splitNext[g*SECTION +: SECTION] = stageCount[g*SECTION +: SECTION] + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  stageCount <= '0;
    else if (strobe.clearAll)   stageCount <= '0;
    else if (strobe.stepSplit)  stageCount <= splitNext;
    else if (strobe.stepSeries) stageCount <= stageCount + 1'b1;
  end

  assign selIdx = skipIn ? IDX_W'(stageSel) : IDX_W'(stageSel) + IDX_W'(SKIP);
  assign selBit = stageCount[selIdx];

  // digital one-shot: reload on each rise of the selected stage
  assign trigger = selBit & ~prevSel;
  assign loadVal = (pulseWidth == '0) ? PW_W'(1) : pulseWidth;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevSel  <= 1'b0;
      pulseCnt <= '0;
    end else if (strobe.clearAll) begin
      prevSel  <= 1'b0;
      pulseCnt <= '0;
    end else begin
      prevSel <= selBit;
      if (trigger)              pulseCnt <= loadVal;
      else if (pulseCnt != '0)  pulseCnt <= pulseCnt - 1'b1;
    end
  end

  always_comb begin
    if (strobe.forceLow)       timerOut = 1'b0;
    else if (strobe.forceHigh) timerOut = 1'b1;
    else if (pulseEn)          timerOut = (pulseCnt != '0);
    else                       timerOut = selBit;
  end
endmodule

// File: rtl/prog_interval_timer.sv
`timescale 1ns/1ps
module prog_interval_timer #(
  parameter int STAGES  = 24,
  parameter int SECTION = 8,
  parameter int SKIP    = 8,
  parameter int SEL_W   = 4,
  parameter int PW_W    = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             countIn,
  input  logic             clearIn,
  input  logic             preloadIn,
  input  logic             holdIn,
  input  logic             skipIn,
  input  logic [SEL_W-1:0] stageSel,
  input  logic             pulseEn,
  input  logic [PW_W-1:0]  pulseWidth,
  output logic             timerOut
);
  timer_pkg::timerStrobe_t strobe;
  logic [STAGES-1:0]       stageCount;

  timer_ctrl #(.SYNC_STAGES(2)) u_ctrl (
    .clk(clk), .rstN(rstN), .countIn(countIn), .clearIn(clearIn),
    .preloadIn(preloadIn), .holdIn(holdIn), .skipIn(skipIn), .strobe(strobe)
  );

  timer_datapath #(
    .STAGES(STAGES), .SECTION(SECTION), .SKIP(SKIP), .SEL_W(SEL_W), .PW_W(PW_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .skipIn(skipIn), .stageSel(stageSel),
    .pulseEn(pulseEn), .pulseWidth(pulseWidth), .stageCount(stageCount),
    .timerOut(timerOut)
  );
endmodule

// File: rtl/timer_checks.sv
`timescale 1ns/1ps
module timer_checks #(
  parameter int STAGES = 24
) (
  input logic              clk,
  input logic              rstN,
  input logic              clearIn,
  input logic              preloadIn,
  input logic              holdIn,
  input logic              skipIn,
  input logic              timerOut,
  input logic [STAGES-1:0] stageCount
);
  assert_clear_low_R4: assert property (@(posedge clk) disable iff (!rstN)
    (clearIn && !(preloadIn && skipIn)) |-> !timerOut);

  assert_preload_high_R5: assert property (@(posedge clk) disable iff (!rstN)
    (preloadIn && !clearIn) |-> timerOut);

  assert_hold_frozen_R6: assert property (@(posedge clk) disable iff (!rstN)
    (holdIn && !clearIn && !preloadIn) |=> $stable(stageCount));

  assert_single_step_R1: assert property (@(posedge clk) disable iff (!rstN)
    (!clearIn && !preloadIn) |=>
      (stageCount == $past(stageCount) ||
       stageCount == STAGES'($past(stageCount) + 1'b1)));

  assert_clear_empties_R4: assert property (@(posedge clk) disable iff (!rstN)
    (clearIn && !(preloadIn && skipIn)) |=> (stageCount == '0));
endmodule

bind prog_interval_timer timer_checks #(.STAGES(STAGES)) u_checks (
  .clk(clk), .rstN(rstN), .clearIn(clearIn), .preloadIn(preloadIn),
  .holdIn(holdIn), .skipIn(skipIn), .timerOut(timerOut), .stageCount(stageCount)
);

// File: tb/tb_prog_interval_timer.sv
`timescale 1ns/1ps
module tb_prog_interval_timer;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       countIn = 1'b0, clearIn = 1'b0, preloadIn = 1'b0, holdIn = 1'b0;
  logic       skipIn = 1'b0, pulseEn = 1'b0;
  logic [3:0] stageSel = '0;
  logic [7:0] pulseWidth = '0;
  logic       timerOut;
  int         checks = 0, fails = 0, highCount = 0;

  always #2.5 clk = ~clk;

  prog_interval_timer dut (
    .clk(clk), .rstN(rstN), .countIn(countIn), .clearIn(clearIn),
    .preloadIn(preloadIn), .holdIn(holdIn), .skipIn(skipIn), .stageSel(stageSel),
    .pulseEn(pulseEn), .pulseWidth(pulseWidth), .timerOut(timerOut)
  );

  always @(negedge clk) if (timerOut) highCount++;

  typedef struct packed {
    logic [7:0]  splitEdges;
    logic [15:0] seriesEdges;
    logic [23:0] expCount;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{8'h00, 16'd1,   24'h000001},
    '{8'h00, 16'd90,  24'h00005A},
    '{8'hA5, 16'd0,   24'hA5A5A5},
    '{8'h3C, 16'd196, 24'h3C3D00},
    '{8'h81, 16'd127, 24'h818200},
    '{8'h12, 16'd256, 24'h121312}
  };

  task automatic check(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: timerOut=%0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic checkInt(input int act, input int exp, input string req);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic edges(input int n);
    for (int i = 0; i < n; i++) begin
      countIn = 1'b1; waitCyc(3);
      countIn = 1'b0; waitCyc(3);
    end
  endtask

  task automatic readStage(input logic skip, input int code, output logic val);
    skipIn = skip; stageSel = 4'(code); #1; val = timerOut;
  endtask

  task automatic clearPulse();
    preloadIn = 1'b0; clearIn = 1'b1; skipIn = 1'b0; waitCyc(2);
    clearIn = 1'b0; waitCyc(1);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    summary();
  end

  initial begin
    logic v;
    waitCyc(3);
    // R11: output low while and after system reset
    check(timerOut, 1'b0, "R11 in reset");
    rstN = 1'b1; waitCyc(2);
    readStage(1'b1, 0, v); check(v, 1'b0, "R11 after reset");

    // vector walk: preset counts then read every routing
    for (int n = 0; n < NV; n++) begin
      clearIn = 1'b1; skipIn = 1'b0; waitCyc(2);
      if (VECS[n].splitEdges != 0) begin
        preloadIn = 1'b1; skipIn = 1'b1; waitCyc(2);
        edges(int'(VECS[n].splitEdges));
        preloadIn = 1'b0; clearIn = 1'b0; waitCyc(1);
      end else begin
        clearIn = 1'b0; waitCyc(1);
      end
      edges(int'(VECS[n].seriesEdges));
      for (int b = 0; b < 2; b++)
        for (int s = 0; s < 16; s++) begin
          readStage(b[0], s, v);
          check(v, VECS[n].expCount[b ? s : s + 8], b ? "R3 window low" : "R2 window high");
        end
    end

    // R1: stage 1 toggles per falling edge, rising edge alone does nothing
    clearPulse();
    for (int i = 1; i <= 8; i++) begin
      edges(1); readStage(1'b1, 0, v); check(v, 1'(i & 1), "R1 stage1 toggle");
    end
    readStage(1'b1, 3, v); check(v, 1'b1, "R1 eight edges");
    countIn = 1'b1; waitCyc(4);
    readStage(1'b1, 0, v); check(v, 1'b0, "R1 rising ignored");
    countIn = 1'b0; waitCyc(4);
    readStage(1'b1, 0, v); check(v, 1'b1, "R1 falling counts");

    // R4: clear empties and forces low, wins over preload with skip low
    clearIn = 1'b1; skipIn = 1'b1; stageSel = 4'd0; waitCyc(2); #1;
    check(timerOut, 1'b0, "R4 clear forces low");
    skipIn = 1'b0; preloadIn = 1'b1; waitCyc(2); #1;
    check(timerOut, 1'b0, "R4 clear beats preload");
    preloadIn = 1'b0; clearIn = 1'b0; waitCyc(1);
    readStage(1'b1, 3, v); check(v, 1'b0, "R4 stages emptied");
    readStage(1'b0, 0, v); check(v, 1'b0, "R4 stays low after release");

    // R5: preload then first edge drops output, second edge counts
    preloadIn = 1'b1; skipIn = 1'b1; stageSel = 4'd0; edges(2); #1;
    check(timerOut, 1'b1, "R5 preload high");
    preloadIn = 1'b0; waitCyc(3); #1;
    check(timerOut, 1'b1, "R5 armed after release");
    edges(1); #1;
    check(timerOut, 1'b0, "R5 first edge drops, no count");
    readStage(1'b1, 1, v); check(v, 1'b0, "R5 count still zero");
    edges(1);
    readStage(1'b1, 0, v); check(v, 1'b1, "R5 second edge counts");

    // R6: hold freezes count
    clearPulse(); edges(3);
    holdIn = 1'b1; edges(4);
    readStage(1'b1, 0, v); check(v, 1'b1, "R6 held bit0");
    readStage(1'b1, 1, v); check(v, 1'b1, "R6 held bit1");
    readStage(1'b1, 2, v); check(v, 1'b0, "R6 held bit2");
    holdIn = 1'b0; waitCyc(1); edges(1);
    readStage(1'b1, 2, v); check(v, 1'b1, "R6 resumes bit2");
    readStage(1'b1, 0, v); check(v, 1'b0, "R6 resumes bit0");

    // R7 and R8: fill sections, leave test mode, roll over
    clearIn = 1'b1; skipIn = 1'b0; waitCyc(2);
    preloadIn = 1'b1; skipIn = 1'b1; waitCyc(2);
    edges(255);
    for (int s = 0; s < 16; s++) begin
      readStage(1'b1, s, v); check(v, 1'b1, "R7 sections full");
    end
    preloadIn = 1'b0; clearIn = 1'b0; waitCyc(2);
    readStage(1'b0, 15, v); check(v, 1'b1, "R8 exit keeps count");
    readStage(1'b0, 8, v); check(v, 1'b1, "R8 exit keeps stage17");
    edges(1);
    for (int b = 0; b < 2; b++)
      for (int s = 0; s < 16; s++) begin
        readStage(b[0], s, v); check(v, 1'b0, "R8 rollover to zero");
      end

    // R9 and R10: pulse mode on stage 2
    pulseEn = 1'b1; pulseWidth = 8'd5; clearPulse();
    skipIn = 1'b1; stageSel = 4'd1;
    begin
      int base;
      base = highCount;
      edges(1); waitCyc(10); checkInt(highCount - base, 0, "R9 no pulse on edge 1");
      edges(1); waitCyc(10); checkInt(highCount - base, 5, "R10 width five");
      edges(3); waitCyc(10); checkInt(highCount - base, 5, "R9 quiet between pulses");
      edges(1); waitCyc(10); checkInt(highCount - base, 10, "R9 repeat after four edges");
      pulseWidth = 8'd0; clearPulse(); skipIn = 1'b1; stageSel = 4'd1;
      base = highCount;
      edges(2); waitCyc(10); checkInt(highCount - base, 1, "R10 zero width gives one");
    end
    pulseEn = 1'b0;

    summary();
  end
endmodule